// File: doc/BRIEF.md
# Link/Conditional Reservation Monitor

This block sits between several processor ports and one shared, word-addressed memory. It gives software an atomic read-modify-write. A port first issues a linked load, which returns the current word and opens a reservation on that address. Later the port issues a conditional store. That store writes the word only if the reservation is still open. Its response is a flag instead of data: 1 when the write happened, 0 when it was refused. On a refusal, software retries the pair. A successful pair therefore acts as an atomic swap or an atomic increment.

Ports request with a valid bit and hold the request until they see their grant. One request is served per cycle, chosen by fixed priority: the lowest port index wins. Because of this, every effect of an earlier access is visible to a later one, including reservation cancellations. The response comes back in the cycle after the grant on a shared data bus, with a valid bit per port.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no response is valid, no reservation is held, and a conditional store issued before any linked load fails with result 0.
- R2: At most one port is granted per cycle. When any port requests, the lowest-numbered requesting port is granted. Same-cycle requests are answered in ascending port order on consecutive cycles.
- R3: The response comes one cycle after the grant. Opcode 2'b00 (load) and 2'b10 (linked load) return the stored word and do not write. Opcode 2'b01 (store) writes the word and returns 0.
- R4: Opcode 2'b11 (conditional store) to the address of the port's open reservation writes the data and returns 1. Its result only ever uses bit 0.
- R5: A conditional store that fails leaves memory unchanged.
- R6: A store from another port to a reserved address cancels that reservation, so a later conditional store from the owner fails.
- R7: A store to a different address leaves the reservation intact.
- R8: A conditional store whose address differs from the port's reserved address fails.
- R9: A new linked load replaces the port's previous reservation.
- R10: Every conditional store ends the issuing port's own reservation, so a second conditional store without a new linked load fails.
- R11: A successful conditional store cancels other ports' reservations on the same address.
- R12: When requests collide in one cycle, a write granted earlier cancels reservations before a later-granted conditional store is evaluated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NP | Request per port, held until granted |
| req_op | input | 2*NP | Opcode per port: 00 load, 01 store, 10 linked load, 11 conditional store |
| req_addr | input | AW*NP | Word address per port |
| req_wdata | input | DW*NP | Write data per port |
| req_grant | output | NP | One-hot grant, same cycle as the request |
| rsp_valid | output | NP | Response valid per port, one cycle after grant |
| rsp_data | output | DW | Read word, or 0/1 result of a conditional store |

## Verification
Isolated pairs test the basic success path. Pairs with a foreign store in between test cancellation: a store to the same address must cancel, while a store to a different address must not. Pairs with a mismatched address, a replaced reservation or a repeated conditional store separate the ways a reservation can end. Multi-port requests in one cycle check the grant order. They also show whether a later conditional store sees the cancellation caused by an earlier write in the same batch. A cycle-level behavioural model checks every grant and every response throughout.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_prio_arb.sv
module llsc_prio_arb #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx
);
  always_comb begin
    logic taken;
    gnt   = '0;
    idx   = '0;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        idx    = IW'(i);
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table
  import llsc_pkg::*;
#(
  parameter int NP = 3,
  parameter int AW = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_en,
  input  logic [IW-1:0] op_port,
  input  llsc_op_e      op,
  input  logic [AW-1:0] op_addr,
  input  logic          wr_commit,
  output logic          hit
);
  logic [NP-1:0] valid_q, valid_d, addr_en;
  logic [AW-1:0] addr_q [NP];

  for (genvar p = 0; p < NP; p++) begin : g_slot
    logic own, set_r, clr_r;
    assign own    = op_en && (op_port == IW'(p));
    assign set_r  = own && (op == OP_LINK);
    assign clr_r  = (own && (op == OP_COND)) ||
                    (wr_commit && (addr_q[p] == op_addr));
    assign addr_en[p] = set_r;

    always_comb begin
      valid_d[p] = valid_q[p];
      if (set_r)      valid_d[p] = 1'b1;
      else if (clr_r) valid_d[p] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (addr_en[p]) addr_q[p] <= op_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_comb begin
    hit = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (op_port == IW'(p)) hit = valid_q[p] && (addr_q[p] == op_addr);
    end
  end
endmodule

// File: rtl/llsc_word_store.sv
module llsc_word_store #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NP = 3,
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    req_valid,
  input  logic [2*NP-1:0]  req_op,
  input  logic [AW*NP-1:0] req_addr,
  input  logic [DW*NP-1:0] req_wdata,
  output logic [NP-1:0]    req_grant,
  output logic [NP-1:0]    rsp_valid,
  output logic [DW-1:0]    rsp_data
);
  localparam int IW = (NP > 1) ? $clog2(NP) : 1;

  logic [IW-1:0] sel_idx;
  logic          any_req;
  llsc_op_e      sel_op;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_wdata;
  logic [DW-1:0] mem_rdata;
  logic          resv_hit, sc_ok, mem_we;
  logic [NP-1:0] rsp_valid_q, rsp_valid_d;
  logic [DW-1:0] rsp_data_q, rsp_data_d;

  llsc_prio_arb #(.N(NP), .IW(IW)) i_arb (
    .req (req_valid),
    .gnt (req_grant),
    .idx (sel_idx)
  );

  assign any_req = |req_valid;

  always_comb begin
    sel_op    = OP_LOAD;
    sel_addr  = '0;
    sel_wdata = '0;
    for (int p = 0; p < NP; p++) begin
      if (sel_idx == IW'(p)) begin
        sel_op    = llsc_op_e'(req_op[2*p +: 2]);
        sel_addr  = req_addr[AW*p +: AW];
        sel_wdata = req_wdata[DW*p +: DW];
      end
    end
  end

  llsc_resv_table #(.NP(NP), .AW(AW), .IW(IW)) i_resv (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_en     (any_req),
    .op_port   (sel_idx),
    .op        (sel_op),
    .op_addr   (sel_addr),
    .wr_commit (mem_we),
    .hit       (resv_hit)
  );

  assign sc_ok  = (sel_op == OP_COND) && resv_hit;
  assign mem_we = any_req && ((sel_op == OP_STORE) || sc_ok);

  llsc_word_store #(.AW(AW), .DW(DW)) i_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (sel_addr),
    .wdata (sel_wdata),
    .rdata (mem_rdata)
  );

  always_comb begin
    rsp_valid_d = req_grant;
    rsp_data_d  = rsp_data_q;
    if (any_req) begin
      unique case (sel_op)
        OP_LOAD, OP_LINK: rsp_data_d = mem_rdata;
        OP_STORE:         rsp_data_d = '0;
        OP_COND:          rsp_data_d = DW'(sc_ok);
        default:          rsp_data_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= '0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (any_req) rsp_data_q <= rsp_data_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk
  import llsc_pkg::*;
#(
  parameter int NP = 3,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NP-1:0] req_valid,
  input logic [NP-1:0] req_grant,
  input logic [NP-1:0] rsp_valid,
  input logic [DW-1:0] rsp_data,
  input llsc_op_e      sel_op,
  input logic          resv_hit,
  input logic          mem_we
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_grant)); // R2
  AST_GRANT_WHEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_valid) |-> (|req_grant)); // R2
  AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant & ~req_valid) == '0); // R2
  AST_RSP_TRACKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_grant) |=> (rsp_valid == $past(req_grant))); // R3
  AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_grant) |=> (rsp_valid == '0)); // R1
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_grant) && (sel_op == OP_LOAD || sel_op == OP_LINK)) |-> !mem_we); // R3
  AST_COND_FLAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_grant) && sel_op == OP_COND) |=> (rsp_data[DW-1:1] == '0)); // R4
  AST_FAILED_COND_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_grant) && sel_op == OP_COND && !resv_hit) |-> !mem_we); // R5
endmodule

bind llsc_monitor llsc_monitor_chk #(.NP(NP), .DW(DW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_grant (req_grant),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .sel_op    (sel_op),
  .resv_hit  (resv_hit),
  .mem_we    (mem_we)
);

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;
  localparam int NP = 3;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam time CLK_PERIOD = 10ns;

  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NP-1:0]    req_valid = '0;
  logic [2*NP-1:0]  req_op = '0;
  logic [AW*NP-1:0] req_addr = '0;
  logic [DW*NP-1:0] req_wdata = '0;
  logic [NP-1:0]    req_grant, rsp_valid;
  logic [DW-1:0]    rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  llsc_monitor #(.NP(NP), .AW(AW), .DW(DW)) i_llsc_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural reference: memory, reservations and expected responses.
  logic [DW-1:0] ref_mem [DEPTH];
  bit            ref_v [NP];
  int            ref_a [NP];
  logic [NP-1:0] exp_valid = '0;
  logic [DW-1:0] exp_data = '0;
  string         exp_tag = "R3";

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) ref_v[i] = 0;
      exp_valid = '0;
    end else begin
      int g;
      g = -1;
      for (int i = 0; i < NP; i++) if (req_valid[i] && g < 0) g = i;
      chk("R2 grant", DW'(req_grant), (g < 0) ? '0 : DW'(1 << g));
      exp_valid = '0;
      if (g >= 0) begin
        logic [1:0] op;
        int a;
        logic [DW-1:0] d;
        bit wr;
        op = req_op[2*g +: 2];
        a  = int'(req_addr[AW*g +: AW]);
        d  = req_wdata[DW*g +: DW];
        exp_valid[g] = 1'b1;
        wr = 0;
        exp_tag = (op == SC) ? "R4 model" : "R3 model";
        case (op)
          LD: exp_data = ref_mem[a];
          LL: begin exp_data = ref_mem[a]; ref_v[g] = 1; ref_a[g] = a; end
          ST: begin exp_data = '0; wr = 1; end
          default: begin
            wr = ref_v[g] && (ref_a[g] == a);
            exp_data = wr ? DW'(1) : DW'(0);
            ref_v[g] = 0;
          end
        endcase
        if (wr) begin
          ref_mem[a] = d;
          for (int i = 0; i < NP; i++) if (ref_a[i] == a) ref_v[i] = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 rsp_valid", DW'(rsp_valid), DW'(exp_valid));
      if (exp_valid != '0) chk(exp_tag, rsp_data, exp_data);
    end
  end

  task automatic single(input int p, input logic [1:0] op, input int a,
                        input logic [DW-1:0] d, output logic [DW-1:0] r);
    @(negedge clk);
    req_op[2*p +: 2]     = op;
    req_addr[AW*p +: AW] = AW'(a);
    req_wdata[DW*p +: DW] = d;
    req_valid[p] = 1'b1;
    @(negedge clk);
    req_valid[p] = 1'b0;
    r = rsp_data;
  endtask

  logic [1:0]    m_op [NP];
  int            m_addr [NP];
  logic [DW-1:0] m_data [NP];
  logic [DW-1:0] m_res [NP];
  int            m_order [NP];

  task automatic multi(input logic [NP-1:0] en);
    logic [NP-1:0] pending, g;
    int cyc;
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      req_op[2*p +: 2]      = m_op[p];
      req_addr[AW*p +: AW]  = AW'(m_addr[p]);
      req_wdata[DW*p +: DW] = m_data[p];
    end
    req_valid = en;
    pending = en;
    cyc = 0;
    while (pending != '0) begin
      #1 g = req_grant;
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        if (g[p]) begin
          m_res[p] = rsp_data;
          m_order[p] = cyc;
          req_valid[p] = 1'b0;
          pending[p] = 1'b0;
        end
      end
      cyc++;
    end
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(16'h1000 + a * 3);
  endfunction

  initial begin
    logic [DW-1:0] r;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", DW'(rsp_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", DW'(rsp_valid), '0);

    for (int a = 0; a < DEPTH; a++) begin
      single(1, ST, a, init_val(a), r);
      chk("R3 store result", r, '0);
    end
    single(0, SC, 5, 16'hDEAD, r);
    chk("R1 cond without link", r, 16'd0);
    single(2, LD, 5, '0, r);
    chk("R5 memory kept", r, init_val(5));

    single(0, LL, 3, '0, r);
    chk("R3 link returns word", r, init_val(3));
    single(0, SC, 3, 16'hAAAA, r);
    chk("R4 cond success", r, 16'd1);
    single(1, LD, 3, '0, r);
    chk("R4 cond wrote", r, 16'hAAAA);

    single(1, LL, 7, '0, r);
    single(2, ST, 7, 16'h7777, r);
    single(1, SC, 7, 16'h1111, r);
    chk("R6 foreign store cancels", r, 16'd0);
    single(0, LD, 7, '0, r);
    chk("R5 failed cond no write", r, 16'h7777);

    single(0, LL, 8, '0, r);
    single(2, ST, 9, 16'h9999, r);
    single(0, SC, 8, 16'h8888, r);
    chk("R7 other address keeps", r, 16'd1);

    single(0, LL, 2, '0, r);
    single(0, SC, 4, 16'h4444, r);
    chk("R8 address mismatch", r, 16'd0);
    single(0, LD, 4, '0, r);
    chk("R5 mismatch no write", r, init_val(4));

    single(1, LL, 10, '0, r);
    single(1, LL, 11, '0, r);
    single(1, SC, 10, 16'h0A0A, r);
    chk("R9 replaced reservation", r, 16'd0);
    single(1, LL, 11, '0, r);
    single(1, SC, 11, 16'h0B0B, r);
    chk("R9 new reservation", r, 16'd1);

    single(2, LL, 12, '0, r);
    single(2, SC, 12, 16'h0C0C, r);
    chk("R10 first cond", r, 16'd1);
    single(2, SC, 12, 16'h0D0D, r);
    chk("R10 second cond", r, 16'd0);

    single(0, LL, 13, '0, r);
    single(1, LL, 13, '0, r);
    single(1, SC, 13, 16'h1313, r);
    chk("R11 winner", r, 16'd1);
    single(0, SC, 13, 16'h3131, r);
    chk("R11 loser", r, 16'd0);

    for (int p = 0; p < NP; p++) begin
      m_op[p] = LD; m_addr[p] = p; m_data[p] = '0;
    end
    multi(3'b111);
    for (int p = 0; p < NP; p++) chk("R2 order", DW'(m_order[p]), DW'(p));

    single(0, LL, 14, '0, r);
    single(2, LL, 14, '0, r);
    m_op[0] = SC; m_addr[0] = 14; m_data[0] = init_val(14) + 1;
    m_op[2] = SC; m_addr[2] = 14; m_data[2] = init_val(14) + 2;
    multi(3'b101);
    chk("R12 first cond", m_res[0], 16'd1);
    chk("R12 later cond", m_res[2], 16'd0);
    single(1, LD, 14, '0, r);
    chk("R4 increment", r, init_val(14) + 1);

    single(2, LL, 15, '0, r);
    m_op[1] = ST; m_addr[1] = 15; m_data[1] = 16'h5151;
    m_op[2] = SC; m_addr[2] = 15; m_data[2] = 16'h2525;
    multi(3'b110);
    chk("R12 store before cond", m_res[2], 16'd0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule